// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is the output cell that sits between one OR-sum of a programmable logic array and one I/O pad. A single D flip-flop and two selectors shape the sum. The flip-flop is cleared at once by a global clear term and set on a clock edge by a global preset term. A three-bit mode code chooses three things: whether the pad sees the registered or the combinational sum, whether that level is inverted, and whether the array is fed back the register content or the level sampled at the pad.

The cell does not drive a tristate pad itself. It presents a data level and an enable to an external pad buffer. It takes the pad's received level back in for pin-sourced feedback. Several cells share the clock, preset and clear terms, and each has its own sum, enable and mode code.

Top module: `omc_cell`

## Requirements
- R1: With mode code {C2,C1,C0} = 000 or 001 (C1 = 0, C2 = 0), the pad level is the register content, inverted when C0 = 0 and not inverted when C0 = 1. The feedback output equals the register content, never inverted.
- R2: With C1 = 1, the pad level is the current sum, inverted when C0 = 0. The feedback output equals the pad input level. C2 has no effect on any output.
- R3: With mode code 100 or 101, the pad level is the register content, inverted when C0 = 0. The feedback output equals the pad input level, not the register.
- R4: When neither clear nor preset is true, the register loads the sum on each rising clock edge and holds it between edges.
- R5: When preset is true and clear is false at a rising edge, the register becomes 1 whatever the sum is.
- R6: A true clear term forces the register to 0 at once, with no clock edge needed, and holds it at 0 while it stays true.
- R7: When clear and preset are both true, the register stays 0.
- R8: The pad enable output equals the enable term in every mode and at every time.
- R9: After a clear, a registered active-low mode shows 1 at the pad and a registered active-high mode shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| sum_in | input | 1 | OR-sum from the array |
| oe_term | input | 1 | Enable product term for this pad |
| sp_term | input | 1 | Global synchronous preset term |
| ar_term | input | 1 | Global asynchronous clear term, active high |
| mode | input | 3 | Mode code {C2,C1,C0} |
| pad_in | input | 1 | Level received from the pad |
| pad_out | output | 1 | Level to the pad driver |
| pad_oe | output | 1 | Enable for the pad driver |
| fb_out | output | 1 | Feedback returned to the array |

## Verification
The hardest state to reach is a clear that arrives between clock edges while the register holds 1. It must show at the pad and on register feedback before any edge. A second hard case is clear overlapping with preset across an edge. The bench first uses preset to load a 1. It then raises clear in the middle of the low clock phase and checks the outputs before the next edge. After that it keeps both terms true through an edge. In all other cases the bench sweeps every mode code against every sum, pad, enable and preset pattern, and tracks the expected register value arithmetically.

// File: rtl/omc_pkg.sv
package omc_pkg;
    localparam int MODE_W = 3;

    typedef struct packed {
        logic use_reg;      // pad sees register content
        logic act_high;     // no inversion at the pad
        logic fb_reg;       // feedback from register, else from pad
    } omc_route_t;
endpackage

// File: rtl/omc_mode_dec.sv
module omc_mode_dec
    import omc_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output omc_route_t        route
);
    always_comb begin
        route.use_reg  = ~mode[1];
        route.act_high = mode[0];
        route.fb_reg   = ~mode[1] & ~mode[2];
    end
endmodule

// File: rtl/omc_store.sv
module omc_store (
    input  logic clk,
    input  logic d,
    input  logic sp_term,
    input  logic ar_term,
    output logic q
);
    always_ff @(posedge clk or posedge ar_term) begin
        if (ar_term) begin
            q <= 1'b0;
        end else if (sp_term) begin
            q <= 1'b1;
        end else begin
            q <= d;
        end
    end

    a_r4_load: assert property (@(posedge clk) disable iff (ar_term)
        !sp_term |=> q == $past(d));
    a_r5_preset: assert property (@(posedge clk) disable iff (ar_term)
        sp_term |=> q);
    a_r6_clear_holds: assert property (@(posedge clk)
        ar_term |-> !q);
endmodule

// File: rtl/omc_route_mux.sv
module omc_route_mux
    import omc_pkg::*;
(
    input  omc_route_t route,
    input  logic       q,
    input  logic       sum_in,
    input  logic       pad_in,
    output logic       pad_out,
    output logic       fb_out
);
    logic picked;

    always_comb begin
        picked  = route.use_reg ? q : sum_in;
        pad_out = route.act_high ? picked : ~picked;
        fb_out  = route.fb_reg ? q : pad_in;
    end
endmodule

// File: rtl/omc_cell.sv
module omc_cell
    import omc_pkg::*;
(
    input  logic              clk,
    input  logic              sum_in,
    input  logic              oe_term,
    input  logic              sp_term,
    input  logic              ar_term,
    input  logic [MODE_W-1:0] mode,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              fb_out
);
    omc_route_t route;
    logic       q;

    omc_mode_dec u_dec (
        .mode  (mode),
        .route (route)
    );

    omc_store u_store (
        .clk     (clk),
        .d       (sum_in),
        .sp_term (sp_term),
        .ar_term (ar_term),
        .q       (q)
    );

    omc_route_mux u_mux (
        .route   (route),
        .q       (q),
        .sum_in  (sum_in),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .fb_out  (fb_out)
    );

    assign pad_oe = oe_term;

    // R1/R3: registered modes show the sum captured at the previous edge
    a_r3_reg_pad: assert property (@(posedge clk) disable iff (ar_term)
        (!mode[1] && !sp_term) |=>
        (!$stable(mode) || pad_out == (mode[0] ? $past(sum_in) : !$past(sum_in))));
    // R1: register feedback is the uninverted captured sum
    a_r1_reg_fb: assert property (@(posedge clk) disable iff (ar_term)
        (mode[2:1] == 2'b00 && !sp_term) |=>
        (!$stable(mode) || fb_out == $past(sum_in)));
    // R2: pin feedback in combinational modes
    a_r2_pin_fb: assert property (@(posedge clk) disable iff (ar_term)
        mode[1] |-> fb_out == pad_in);
endmodule

// File: tb/omc_cell_tb_top.sv
`timescale 1ns/1ps
module omc_cell_tb_top;
    logic       clk = 1'b0;
    logic       sum_in = 1'b0, oe_term = 1'b0, sp_term = 1'b0, ar_term = 1'b1;
    logic [2:0] mode = 3'b000;
    logic       pad_in = 1'b0;
    logic       pad_out, pad_oe, fb_out;
    logic       exp_q;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    omc_cell dut_i (
        .clk(clk), .sum_in(sum_in), .oe_term(oe_term), .sp_term(sp_term),
        .ar_term(ar_term), .mode(mode), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic picked, exp_pad, exp_fb;
        picked  = mode[1] ? sum_in : exp_q;
        exp_pad = mode[0] ? picked : ~picked;
        exp_fb  = (mode[2:1] == 2'b00) ? exp_q : pad_in;
        chk(req, "pad_out", pad_out, exp_pad);
        chk("R8", "pad_oe", pad_oe, oe_term);
        chk(req, "fb_out", fb_out, exp_fb);
    endtask

    function automatic string mode_req(input logic [2:0] m);
        if (m[1]) return "R2";
        if (m[2]) return "R3";
        return "R1";
    endfunction

    initial begin
        exp_q = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R9 reset state under both registered polarities
        mode = 3'b000; #1; chk("R9", "pad_out low-active", pad_out, 1'b1);
        chk("R1", "fb_out", fb_out, 1'b0);
        mode = 3'b101; #1; chk("R9", "pad_out high-active", pad_out, 1'b0);
        ar_term = 1'b0;

        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            mode    = i[2:0];
            sum_in  = i[3];
            pad_in  = i[4];
            oe_term = i[5];
            sp_term = (i[7:6] == 2'b11);
            #1 check_all(mode_req(mode));
            @(posedge clk);
            exp_q = sp_term ? 1'b1 : sum_in;   // R4, R5
            #2 check_all(sp_term ? "R5" : "R4");
        end

        // R6: clear between edges, register held at 1
        @(negedge clk);
        mode = 3'b000; sp_term = 1'b1; sum_in = 1'b0; pad_in = 1'b1;
        @(posedge clk); exp_q = 1'b1;
        #1 chk("R5", "pad_out preset", pad_out, 1'b0);
        @(negedge clk);
        sp_term = 1'b0; sum_in = 1'b1;
        #1 ar_term = 1'b1;
        #1 exp_q = 1'b0;
        chk("R6", "pad_out async clear", pad_out, 1'b1);
        chk("R6", "fb_out async clear", fb_out, 1'b0);
        // R7: clear and preset together across an edge
        sp_term = 1'b1;
        @(posedge clk); #2;
        chk("R7", "fb_out clear wins", fb_out, 1'b0);
        mode = 3'b001; #1;
        chk("R7", "pad_out clear wins", pad_out, 1'b0);
        @(negedge clk);
        ar_term = 1'b0; sp_term = 1'b0; sum_in = 1'b0;
        @(posedge clk); #2;
        chk("R4", "fb_out after release", fb_out, 1'b0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule